// File: doc/BRIEF.md
# Break-Aware Sticky Status Flag Clear Controller

This block keeps a small set of sticky status flags for a serial port and governs how software clears them. A flag is raised by a one-cycle hardware pulse and stays up until software completes a two-step clear. First, software reads the status register while the flag is up, which arms that flag. Second, software accesses the data register, by read or write, which clears every armed flag.

A break input signals that a debug halt is in progress. A clear-enable bit in a control register decides what software accesses do during the break. With the bit at 0, accesses made while halted leave every flag and every armed bit unchanged, so a debugger can inspect the port without side effects. A sequence begun before the halt is finished by the data access after the halt. With the bit at 1, clearing works during the break as it does at any other time. Hardware set pulses are never gated.

Top module: `brk_flag_clr`

## Requirements
- R1: While `rst_ni` is low, all flags, all armed bits and the clear-enable bit are 0. After reset, reads of status and control return 0.
- R2: A 1 on `set_i[i]` makes `flags_o[i]` 1 at the next clock edge. The flag stays 1 until it is cleared.
- R3: A read is combinational. Address 0 returns `flags_o` in bits [NUM_FLAGS-1:0]. Address 2 returns the clear-enable bit in bit 0. All other bits, and all other addresses, read 0.
- R4: A status read (address 0) while flag i is 1 arms flag i. A later read or write at address 1 clears every armed flag at that edge. Unarmed flags are not affected.
- R5: An access at address 1 with no earlier arming leaves the flags unchanged.
- R6: A set pulse on a flag takes priority over a clear in the same cycle and disarms that flag. A further data access then leaves the flag at 1.
- R7: While `brk_i` is 1 and the clear-enable bit is 0, status reads arm nothing. Data accesses clear no flag and drop no armed bit.
- R8: While `brk_i` is 1 and the clear-enable bit is 1, the normal two-step clear works.
- R9: A flag armed before a break stays 1 through the break while the enable bit is 0. After the break, a single data access clears it.
- R10: A flag cleared during a break stays 0 after the break ends.
- R11: Set pulses raise flags during a break, whatever the enable bit.
- R12: A write at address 2 loads `wdata_i[0]` into the clear-enable bit. This happens whether or not a break is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| brk_i | input | 1 | Debug halt in progress |
| set_i | input | NUM_FLAGS | Hardware flag-set pulses |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| flags_o | output | NUM_FLAGS | Current flag values |

## Verification
Two events can land on the same edge. The first pair is a hardware set pulse and the software data access that would clear the same armed flag. The bench provokes this by arming a flag and then driving its set pulse together with the data access. It expects the flag to stay 1 and to survive a further data access, because that flag is disarmed. The second pair is a break together with an access that would arm or clear a flag. The bench drives this with the enable bit at 0 and at 1. Each case is judged against a behavioural model that updates flags, armed bits and the enable bit on every edge.

// File: rtl/brk_flag_clr_pkg.sv
package brk_flag_clr_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/brk_access_dec.sv
module brk_access_dec
  import brk_flag_clr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              brk_i,
  input  logic              clr_en_i,
  output reg_sel_e          sel_o,
  output logic              arm_o,
  output logic              clr_o,
  output logic              ctrl_we_o
);
  logic sw_ok;

  always_comb begin
    case (addr_i)
      ADDR_W'(0): sel_o = REG_STAT;
      ADDR_W'(1): sel_o = REG_DATA;
      ADDR_W'(2): sel_o = REG_CTRL;
      default:    sel_o = REG_NONE;
    endcase
  end

  // software may touch flags unless halted with clearing locked
  assign sw_ok     = !brk_i || clr_en_i;
  assign arm_o     = sw_ok && rd_i && (sel_o == REG_STAT);
  assign clr_o     = sw_ok && (rd_i || wr_i) && (sel_o == REG_DATA);
  assign ctrl_we_o = wr_i && (sel_o == REG_CTRL);
endmodule

// File: rtl/brk_ctrl_reg.sv
module brk_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wbit_i,
  output logic clr_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   clr_en_o <= 1'b0;
    else if (we_i) clr_en_o <= wbit_i;
  end
endmodule

// File: rtl/brk_flag_cell.sv
module brk_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (set_i) begin
      // new event wins, any half-done clear is forgotten
      flag_o  <= 1'b1;
      armed_o <= 1'b0;
    end else if (clr_i && armed_o) begin
      flag_o  <= 1'b0;
      armed_o <= 1'b0;
    end else if (arm_i && flag_o) begin
      armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/brk_flag_clr.sv
module brk_flag_clr
  import brk_flag_clr_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 brk_i,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  reg_sel_e             sel;
  logic                 arm, clr, ctrl_we, clr_en_q;
  logic [NUM_FLAGS-1:0] armed_q;

  brk_access_dec #(.ADDR_W(ADDR_W)) u_dec (
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .brk_i    (brk_i),
    .clr_en_i (clr_en_q),
    .sel_o    (sel),
    .arm_o    (arm),
    .clr_o    (clr),
    .ctrl_we_o(ctrl_we)
  );

  brk_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wbit_i  (wdata_i[0]),
    .clr_en_o(clr_en_q)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    brk_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i[i]),
      .arm_i  (arm),
      .clr_i  (clr),
      .flag_o (flags_o[i]),
      .armed_o(armed_q[i])
    );
  end

  logic [DATA_W-1:0] stat_word, ctrl_word;
  if (PAD_W > 0) begin : g_pad
    assign stat_word = {{PAD_W{1'b0}}, flags_o};
  end else begin : g_nopad
    assign stat_word = flags_o[DATA_W-1:0];
  end
  assign ctrl_word = {{(DATA_W-1){1'b0}}, clr_en_q};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        REG_STAT: rdata_o = stat_word;
        REG_CTRL: rdata_o = ctrl_word;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/brk_flag_clr_chk.sv
module brk_flag_clr_chk #(
  parameter int NUM_FLAGS = 4,
  parameter int ADDR_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 brk_i,
  input logic [NUM_FLAGS-1:0] set_i,
  input logic                 rd_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic [NUM_FLAGS-1:0] armed_q,
  input logic                 clr_en_q
);
  // R2
  set_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R4
  fall_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flags_o & $past(flags_o) & ~$past(armed_q)) == '0));

  // R7
  brk_lock_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !clr_en_q) |=> ((~flags_o & $past(flags_o)) == '0));

  // R7
  brk_lock_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !clr_en_q && set_i == '0) |=> (armed_q == $past(armed_q)));

  // R6
  set_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((armed_q & $past(set_i)) == '0));

  // R4
  arm_only_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((armed_q & ~flags_o) == '0));
endmodule

bind brk_flag_clr brk_flag_clr_chk #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .brk_i   (brk_i),
  .set_i   (set_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .flags_o (flags_o),
  .armed_q (armed_q),
  .clr_en_q(clr_en_q)
);

// File: tb/sim_brk_flag_clr.sv
module sim_brk_flag_clr;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int AW = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          brk = 1'b0;
  logic [NF-1:0] set = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NF-1:0] flags;

  int checks = 0;
  int errors = 0;

  bit m_flag [NF];
  bit m_arm  [NF];
  bit m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_flag_clr #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .set_i(set), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .flags_o(flags)
  );

  function automatic logic [NF-1:0] m_flags();
    logic [NF-1:0] v;
    for (int i = 0; i < NF; i++) v[i] = m_flag[i];
    return v;
  endfunction

  function automatic logic [DW-1:0] m_rdata();
    logic [DW-1:0] v = '0;
    if (rd && addr == 0) for (int i = 0; i < NF; i++) v[i] = m_flag[i];
    if (rd && addr == 2) v[0] = m_en;
    return v;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive, check read data, clock, update model, check flags
  task automatic step(string tag, logic [NF-1:0] s, bit r, bit w, int a,
                      logic [DW-1:0] wd = '0);
    bit ok, dacc, srd;
    @(negedge clk);
    set = s; rd = r; wr = w; addr = AW'(a); wdata = wd;
    #1;
    chk({tag, " rdata"}, rdata, m_rdata());
    @(posedge clk);
    ok   = !brk || m_en;
    dacc = (r || w) && a == 1;
    srd  = r && a == 0;
    for (int i = 0; i < NF; i++) begin
      if (s[i]) begin m_flag[i] = 1; m_arm[i] = 0; end
      else if (ok && dacc && m_arm[i]) begin m_flag[i] = 0; m_arm[i] = 0; end
      else if (ok && srd && m_flag[i]) m_arm[i] = 1;
    end
    if (w && a == 2) m_en = wd[0];
    #(CLK_PERIOD/4);
    chk({tag, " flags"}, DW'(flags), DW'(m_flags()));
  endtask

  task automatic idle(string tag);
    step(tag, '0, 0, 0, 3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NF; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
    m_en = 0;
    repeat (2) @(negedge clk);
    // R1: outputs during reset
    chk("R1 flags in reset", DW'(flags), '0);
    rst_n = 1'b1;
    step("R1 status", '0, 1, 0, 0);
    step("R1 ctrl", '0, 1, 0, 2);

    // R2: set and hold
    step("R2 set", 4'b0001, 0, 0, 3);
    idle("R2 hold");
    chk("R2 literal", DW'(flags), 8'h01);
    // R3: read map
    step("R3 status", '0, 1, 0, 0);
    step("R3 unused addr", '0, 1, 0, 3);
    step("R3 data addr", '0, 1, 0, 1);
    // R4: two-step clear (status read above already armed flag0)
    step("R4 set other", 4'b0010, 0, 0, 3);
    step("R4 data write", '0, 0, 1, 1);
    chk("R4 literal", DW'(flags), 8'h02);
    // R5: no arm, no clear
    step("R5 data read", '0, 1, 0, 1);
    chk("R5 literal", DW'(flags), 8'h02);
    // R6: set and clear collide
    step("R6 arm", '0, 1, 0, 0);
    step("R6 collide", 4'b0010, 1, 0, 1);
    step("R6 again", '0, 0, 1, 1);
    chk("R6 literal", DW'(flags), 8'h02);
    step("R6 rearm", '0, 1, 0, 0);
    step("R6 clear", '0, 0, 1, 1);
    // R12: enable register
    step("R12 write 1", '0, 0, 1, 2, 8'h01);
    step("R12 read", '0, 1, 0, 2);
    step("R12 write 0", '0, 0, 1, 2, 8'hFE);
    step("R12 read 0", '0, 1, 0, 2);

    // R7: locked break
    step("R7 set", 4'b0100, 0, 0, 3);
    brk = 1'b1;
    step("R7 status", '0, 1, 0, 0);
    step("R7 data", '0, 0, 1, 1);
    chk("R7 literal", DW'(flags), 8'h04);
    brk = 1'b0;
    step("R7 after data", '0, 1, 0, 1);
    chk("R7 no arm kept", DW'(flags), 8'h04);
    step("R7 arm", '0, 1, 0, 0);
    step("R7 clear", '0, 1, 0, 1);

    // R9: arm before break, finish after
    step("R9 set", 4'b1000, 0, 0, 3);
    step("R9 arm", '0, 1, 0, 0);
    brk = 1'b1;
    step("R9 data in brk", '0, 1, 0, 1);
    step("R9 status in brk", '0, 1, 0, 0);
    step("R9 write in brk", '0, 0, 1, 1);
    chk("R9 kept", DW'(flags), 8'h08);
    // R11: set during break
    step("R11 set in brk", 4'b0100, 0, 0, 3);
    chk("R11 literal", DW'(flags), 8'h0C);
    // R12 during break
    step("R12 write in brk", '0, 0, 1, 2, 8'h00);
    brk = 1'b0;
    step("R9 finish", '0, 0, 1, 1);
    chk("R9 literal", DW'(flags), 8'h04);

    // R8 / R10: enabled break
    step("R8 en", '0, 0, 1, 2, 8'h01);
    brk = 1'b1;
    step("R8 set", 4'b0001, 0, 0, 3);
    step("R8 arm", '0, 1, 0, 0);
    step("R8 clear", '0, 1, 0, 1);
    chk("R8 literal", DW'(flags), 8'h00);
    step("R11 set en", 4'b0010, 0, 0, 3);
    brk = 1'b0;
    idle("R10 after");
    step("R10 status", '0, 1, 0, 0);
    chk("R10 literal", DW'(flags), 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule